// File: doc/BRIEF.md
# Four-Wide Group Register Renamer

This block maps the architectural registers of a group of up to four decoded instructions onto physical registers in one clock cycle. Each slot carries a valid bit, a flag that says whether it writes a register, two architectural sources and one architectural destination. Every writing slot is given a fresh physical tag from a short window of free-list tags. Every source is turned into a physical tag. If an earlier slot in the same group writes the source register, the source gets the tag of the closest such slot. Otherwise it gets the tag held in the map table. When one register is written by several slots, each write gets its own tag, and the map table keeps the tag of the last of them.

The group arrives on a valid/ready handshake. The renamed group is presented on the output with `out_valid` in the same cycle, so the block adds no register stage. The group is taken, and the map table updated, on a clock edge where `grp_valid` and `grp_ready` are both high. `grp_ready` requires two things: the consumer's `dn_ready` must be high, and the free list must offer at least as many tags as the group has writing slots. If either is missing, the whole group waits. It is never split. `free_take` tells the free list how many tags were used, starting from entry 0.

Top module: `group_renamer`

## Requirements
- R1: After reset, the map table sends every architectural register r to physical tag r.
- R2: The block needs one free tag for each slot that is valid and writes a register. `grp_ready` is high exactly when `dn_ready` is high and `free_avail` covers that need. `out_valid` is high exactly when `grp_valid` is high and `free_avail` covers that need. Neither signal depends on the other.
- R3: The n-th writing slot, counting in slot order from 0, receives free-list entry n as its destination tag. An architectural register that is written twice in one group therefore receives two different tags. `free_take` equals the number of writing slots.
- R4: A slot that is invalid, or that has no destination, consumes no free-list entry, and its destination tag output is 0.
- R5: When a source of slot k names a register that one of slots 0 to k-1 writes, the source takes the destination tag of the highest-numbered such slot.
- R6: A source that no earlier slot in the group writes takes the tag currently held in the map table. Slot 0 always reads the map table.
- R7: After an accepted group, each register written in the group maps to the tag of its last writer in the group. All other entries keep their old values.
- R8: The map table does not change on a cycle in which no group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A group is presented |
| grp_ready | output | 1 | The group is taken on this edge if `grp_valid` is high |
| slot_valid | input | LANES | Per-slot valid mask |
| slot_has_dst | input | LANES | The slot writes a register |
| src_a | input | LANES*AW | First source register of each slot |
| src_b | input | LANES*AW | Second source register of each slot |
| dst | input | LANES*AW | Destination register of each slot |
| free_tags | input | LANES*PW | Head of the free list; entry 0 is used first |
| free_avail | input | CW | Number of usable entries in `free_tags` |
| dn_ready | input | 1 | The consumer can accept a renamed group |
| out_valid | output | 1 | The renamed group is valid |
| out_src_a_tag | output | LANES*PW | Physical tag of source A for each slot |
| out_src_b_tag | output | LANES*PW | Physical tag of source B for each slot |
| out_dst_tag | output | LANES*PW | New destination tag for each slot |
| free_take | output | CW | Free-list entries consumed by this group |
| map_flat | output | ARCH_REGS*PW | Current map table, one tag per register |

## Verification
Destinations and sources are drawn from a small set of registers, so that repeated writes and reads of a register written earlier in the group happen in most groups. The bench compares every tag with a model that renames one instruction at a time. A comparator that took the farthest earlier writer instead of the nearest would return stale tags for chained writes. A map update with the wrong priority would leave an older tag in the table. The bench sweeps every write mask against every free-list depth. A stall test that counted invalid slots or slots without a destination would hold back groups that fit. Allocation that did not compress past such slots would skip free-list entries or repeat one.

// File: rtl/rn_pkg.sv
package rn_pkg;
  function automatic int count_set(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int LANES = 4,
  parameter int PW    = 6,
  parameter int CW    = 3
) (
  input  logic [LANES-1:0]    writes,
  input  logic [LANES*PW-1:0] free_tags,
  output logic [LANES*PW-1:0] dst_tags,
  output logic [CW-1:0]       need
);
  always_comb begin
    int idx;
    idx = 0;
    dst_tags = '0;
    for (int k = 0; k < LANES; k++) begin
      if (writes[k]) begin
        dst_tags[k*PW +: PW] = free_tags[idx*PW +: PW];
        idx++;
      end
    end
    need = CW'(idx);
  end
endmodule

// File: rtl/rn_src_resolve.sv
module rn_src_resolve #(
  parameter int LANES = 4,
  parameter int SLOT  = 0,
  parameter int AW    = 5,
  parameter int PW    = 6,
  parameter int ARCH_REGS = 32
) (
  input  logic [AW-1:0]             src,
  input  logic [ARCH_REGS*PW-1:0]   map_flat,
  input  logic [LANES-1:0]          writes,
  input  logic [LANES*AW-1:0]       dst,
  input  logic [LANES*PW-1:0]       dst_tags,
  output logic [PW-1:0]             tag
);
  always_comb begin
    tag = map_flat[int'(src)*PW +: PW];
    // ascending scan: the nearest earlier writer is applied last
    for (int j = 0; j < SLOT; j++) begin
      if (writes[j] && dst[j*AW +: AW] == src) tag = dst_tags[j*PW +: PW];
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int LANES = 4,
  parameter int AW    = 5,
  parameter int PW    = 6,
  parameter int ARCH_REGS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [LANES-1:0]        writes,
  input  logic [LANES*AW-1:0]     dst,
  input  logic [LANES*PW-1:0]     dst_tags,
  output logic [ARCH_REGS*PW-1:0] map_flat
);
  logic [PW-1:0] map_q [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH_REGS; r++) map_q[r] <= PW'(r);
    end else if (commit) begin
      // later slots overwrite earlier ones: last writer wins
      for (int k = 0; k < LANES; k++)
        if (writes[k]) map_q[dst[k*AW +: AW]] <= dst_tags[k*PW +: PW];
    end
  end

  for (genvar r = 0; r < ARCH_REGS; r++) begin : g_flat
    assign map_flat[r*PW +: PW] = map_q[r];
  end
endmodule

// File: rtl/group_renamer.sv
module group_renamer #(
  parameter int LANES     = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    grp_valid,
  output logic                    grp_ready,
  input  logic [LANES-1:0]        slot_valid,
  input  logic [LANES-1:0]        slot_has_dst,
  input  logic [LANES*AW-1:0]     src_a,
  input  logic [LANES*AW-1:0]     src_b,
  input  logic [LANES*AW-1:0]     dst,
  input  logic [LANES*PW-1:0]     free_tags,
  input  logic [CW-1:0]           free_avail,
  input  logic                    dn_ready,
  output logic                    out_valid,
  output logic [LANES*PW-1:0]     out_src_a_tag,
  output logic [LANES*PW-1:0]     out_src_b_tag,
  output logic [LANES*PW-1:0]     out_dst_tag,
  output logic [CW-1:0]           free_take,
  output logic [ARCH_REGS*PW-1:0] map_flat
);
  logic [LANES-1:0] writes;
  logic [CW-1:0]    need;
  logic             fits;

  assign writes = slot_valid & slot_has_dst;

  rn_alloc #(.LANES(LANES), .PW(PW), .CW(CW)) u_alloc (
    .writes(writes), .free_tags(free_tags), .dst_tags(out_dst_tag), .need(need)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rn_src_resolve #(.LANES(LANES), .SLOT(k), .AW(AW), .PW(PW), .ARCH_REGS(ARCH_REGS)) u_a (
      .src(src_a[k*AW +: AW]), .map_flat(map_flat), .writes(writes), .dst(dst),
      .dst_tags(out_dst_tag), .tag(out_src_a_tag[k*PW +: PW])
    );
    rn_src_resolve #(.LANES(LANES), .SLOT(k), .AW(AW), .PW(PW), .ARCH_REGS(ARCH_REGS)) u_b (
      .src(src_b[k*AW +: AW]), .map_flat(map_flat), .writes(writes), .dst(dst),
      .dst_tags(out_dst_tag), .tag(out_src_b_tag[k*PW +: PW])
    );
  end

  assign fits      = free_avail >= need;
  assign grp_ready = dn_ready && fits;
  assign out_valid = grp_valid && fits;
  assign free_take = need;

  rn_map_table #(.LANES(LANES), .AW(AW), .PW(PW), .ARCH_REGS(ARCH_REGS)) u_map (
    .clk(clk), .rst_n(rst_n), .commit(grp_valid && grp_ready), .writes(writes),
    .dst(dst), .dst_tags(out_dst_tag), .map_flat(map_flat)
  );
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int LANES = 4,
  parameter int ARCH_REGS = 32,
  parameter int AW = 5,
  parameter int PW = 6,
  parameter int CW = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    grp_valid,
  input logic                    grp_ready,
  input logic                    out_valid,
  input logic [LANES-1:0]        slot_valid,
  input logic [LANES-1:0]        slot_has_dst,
  input logic [LANES*AW-1:0]     src_a,
  input logic [LANES*AW-1:0]     dst,
  input logic [CW-1:0]           free_avail,
  input logic [CW-1:0]           free_take,
  input logic [LANES*PW-1:0]     out_src_a_tag,
  input logic [LANES*PW-1:0]     out_dst_tag,
  input logic [ARCH_REGS*PW-1:0] map_flat
);
  logic fire;
  assign fire = grp_valid && grp_ready;

  assert_take_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> free_take <= free_avail);

  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> out_valid);

  assert_hold_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(map_flat));

  assert_slot0_reads_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[0] |-> out_src_a_tag[0 +: PW] == map_flat[int'(src_a[0 +: AW])*PW +: PW]);

  assert_slot1_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid[0] && slot_has_dst[0] && slot_valid[1] && src_a[AW +: AW] == dst[0 +: AW])
      |-> out_src_a_tag[PW +: PW] == out_dst_tag[0 +: PW]);

  assert_last_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && slot_valid[LANES-1] && slot_has_dst[LANES-1])
      |=> map_flat[int'($past(dst[(LANES-1)*AW +: AW]))*PW +: PW]
          == $past(out_dst_tag[(LANES-1)*PW +: PW]));
endmodule

bind group_renamer rn_checker #(
  .LANES(LANES), .ARCH_REGS(ARCH_REGS), .AW(AW), .PW(PW), .CW(CW)
) u_rn_checker (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
  .out_valid(out_valid), .slot_valid(slot_valid), .slot_has_dst(slot_has_dst),
  .src_a(src_a), .dst(dst), .free_avail(free_avail), .free_take(free_take),
  .out_src_a_tag(out_src_a_tag), .out_dst_tag(out_dst_tag), .map_flat(map_flat)
);

// File: tb/tb_group_renamer.sv
module tb_group_renamer;
  localparam int L = 4, A = 32, P = 64;
  localparam int AW = 5, PW = 6, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic grp_valid, grp_ready, dn_ready, out_valid;
  logic [L-1:0] slot_valid, slot_has_dst;
  logic [L*AW-1:0] src_a, src_b, dst;
  logic [L*PW-1:0] free_tags, out_src_a_tag, out_src_b_tag, out_dst_tag;
  logic [CW-1:0] free_avail, free_take;
  logic [A*PW-1:0] map_flat;

  group_renamer #(.LANES(L), .ARCH_REGS(A), .PHYS_REGS(P)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [PW-1:0] ref_map [A];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_map(input string req);
    for (int r = 0; r < A; r++)
      chk(map_flat[r*PW +: PW] == ref_map[r], req, $sformatf("map[%0d]", r),
          int'(map_flat[r*PW +: PW]), int'(ref_map[r]));
  endtask

  task automatic run_group(input bit gv, input bit dr, input logic [L-1:0] sv, input logic [L-1:0] hd,
                           input int sa[L], input int sb[L], input int d[L],
                           input int avail, input int base);
    logic [PW-1:0] tm [A];
    int need, idx, exp_tag;
    bit wr_a, wr_b;
    bit written [A];
    @(negedge clk);
    grp_valid = gv; dn_ready = dr; slot_valid = sv; slot_has_dst = hd;
    free_avail = CW'(avail);
    for (int k = 0; k < L; k++) begin
      src_a[k*AW +: AW] = AW'(sa[k]);
      src_b[k*AW +: AW] = AW'(sb[k]);
      dst[k*AW +: AW]   = AW'(d[k]);
      free_tags[k*PW +: PW] = PW'((base + k) % P);
    end
    #1;
    need = 0;
    for (int k = 0; k < L; k++) if (sv[k] && hd[k]) need++;
    chk(grp_ready == (dr && avail >= need), "R2", "grp_ready", int'(grp_ready), int'(dr && avail >= need));
    chk(out_valid == (gv && avail >= need), "R2", "out_valid", int'(out_valid), int'(gv && avail >= need));
    chk(int'(free_take) == need, "R3", "free_take", int'(free_take), need);
    check_map("R8");
    for (int r = 0; r < A; r++) begin tm[r] = ref_map[r]; written[r] = 0; end
    idx = 0;
    for (int k = 0; k < L; k++) begin
      if (sv[k]) begin
        wr_a = written[sa[k]]; wr_b = written[sb[k]];
        chk(out_src_a_tag[k*PW +: PW] == tm[sa[k]], wr_a ? "R5" : "R6", $sformatf("src_a slot %0d", k),
            int'(out_src_a_tag[k*PW +: PW]), int'(tm[sa[k]]));
        chk(out_src_b_tag[k*PW +: PW] == tm[sb[k]], wr_b ? "R5" : "R6", $sformatf("src_b slot %0d", k),
            int'(out_src_b_tag[k*PW +: PW]), int'(tm[sb[k]]));
      end
      if (sv[k] && hd[k]) begin
        exp_tag = (base + idx) % P;
        chk(int'(out_dst_tag[k*PW +: PW]) == exp_tag, "R3", $sformatf("dst slot %0d", k),
            int'(out_dst_tag[k*PW +: PW]), exp_tag);
        tm[d[k]] = PW'(exp_tag); written[d[k]] = 1; idx++;
      end else begin
        chk(out_dst_tag[k*PW +: PW] == '0, "R4", $sformatf("dst slot %0d", k),
            int'(out_dst_tag[k*PW +: PW]), 0);
      end
    end
    if (gv && dr && avail >= need)
      for (int r = 0; r < A; r++) ref_map[r] = tm[r];
    @(posedge clk);
  endtask

  initial begin
    int sa[L], sb[L], d[L];
    int base;
    grp_valid = 0; dn_ready = 0; slot_valid = '0; slot_has_dst = '0;
    src_a = '0; src_b = '0; dst = '0; free_tags = '0; free_avail = '0;
    for (int r = 0; r < A; r++) ref_map[r] = PW'(r);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_map("R1");
    base = 32;
    // sweep: every write mask against every free-list depth, both handshake sides
    for (int m = 0; m < 16; m++) begin
      for (int av = 0; av <= L; av++) begin
        for (int hs = 0; hs < 4; hs++) begin
          for (int k = 0; k < L; k++) begin
            sa[k] = (k + m) % 4; sb[k] = (k + av) % 4; d[k] = (k * m + av) % 3;
          end
          run_group(hs[0], hs[1], 4'hF, 4'(m), sa, sb, d, av, base);
          base = (base + 4) % P;
        end
      end
    end
    // invalid-slot masks with writes requested (R4)
    for (int vm = 0; vm < 16; vm++) begin
      for (int k = 0; k < L; k++) begin sa[k] = k; sb[k] = 3 - k; d[k] = (k + vm) % 2; end
      run_group(1, 1, 4'(vm), 4'hF, sa, sb, d, L, base);
      base = (base + 4) % P;
    end
    // chained writes to one register, nearest-writer check (R5, R7)
    for (int k = 0; k < L; k++) begin sa[k] = 1; sb[k] = 2; d[k] = 1; end
    run_group(1, 1, 4'hF, 4'hF, sa, sb, d, L, base);
    base = (base + 4) % P;
    // random groups over a small register set
    for (int n = 0; n < 1500; n++) begin
      for (int k = 0; k < L; k++) begin
        sa[k] = $urandom_range(0, 4); sb[k] = $urandom_range(0, 4); d[k] = $urandom_range(0, 3);
      end
      run_group($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
                4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                sa, sb, d, $urandom_range(0, 3) == 0 ? $urandom_range(0, L) : L, base);
      base = (base + 4) % P;
    end
    // idle cycle: map must hold the last writers (R7) and stay put (R8)
    @(negedge clk);
    grp_valid = 0;
    #1 check_map("R7");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule